// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the input pins of an eight-pin general purpose port and turns pin activity into interrupts. Each pin holds a stored data value. On every clock the block takes the new sampled value of each pin that is set as an input. Three configuration vectors choose, per pin, the detection type. A pin can fire on the falling edge, the rising edge, either edge, a low level or a high level. A detected event sets a sticky raw status bit. The mask vector filters the raw status into a masked status, and a single active-high request line is the OR of the masked status.

Software clears raw status by pulsing a clear strobe with a vector of bits to drop. A new event in the same cycle overrides the clear. The request line is a combinational function of the raw status register and the mask input. A change of the mask shows on the request line within the same cycle. Changes to the detection configuration take effect on the next clock edge. Upstream logic must synchronize the pin inputs, and a separate bus block drives the configuration inputs.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the stored pin data, the raw status, the masked status and the request line are all zero.
- R2: On each clock edge, a pin whose direction bit is 0 (input) takes `pin_in` into its stored data bit. A pin whose direction bit is 1 (output) keeps its stored data bit.
- R3: Detection type per pin: sense=0 selects edge and sense=1 selects level. In edge mode with both-edges=1, any change of the stored data bit sets the raw status bit on the same edge that the data bit updates.
- R4: In edge mode with both-edges=0, polarity=1 sets raw status only on a 0-to-1 change and polarity=0 only on a 1-to-0 change. The opposite edge and an unchanged value leave it as it was.
- R5: In level mode, polarity=1 sets raw status on every edge where the stored data bit is 1. Polarity=0 does the same where the stored data bit is 0. A bit that is cleared while its level persists is set again on the same edge.
- R6: `masked_status` equals raw status AND `irq_mask`. `irq` is 1 exactly when `masked_status` is non-zero. A change of `irq_mask` reaches `irq` without waiting for a clock edge.
- R7: A clock edge with `clr_we`=1 clears every raw status bit whose `clr_mask` bit is 1. Bits with `clr_mask` 0 keep their value.
- R8: When a clear and a new event hit the same bit on the same edge, the bit ends up set.
- R9: An output pin never changes its stored data. For that reason, toggling `pin_in` on an output pin in edge mode sets no raw status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NPINS | Synchronized pin values |
| pin_dir | input | NPINS | 1 = output, 0 = input, per pin |
| det_sense | input | NPINS | 0 = edge, 1 = level, per pin |
| det_both | input | NPINS | 1 = either edge (edge mode) |
| det_pol | input | NPINS | Edge or level polarity: 1 = rising/high, 0 = falling/low |
| irq_mask | input | NPINS | Per-pin interrupt enable |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | NPINS | Raw status bits to clear when `clr_we` is 1 |
| pin_data | output | NPINS | Stored pin data |
| raw_status | output | NPINS | Sticky raw interrupt status |
| masked_status | output | NPINS | Raw status AND mask |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a clear and a fresh event landing on the same bit on the same edge. The level-mode re-set that follows a clear of a persisting level is nearly as hard. The sweep therefore asserts the clear strobe on every cycle while it walks all 256 pin patterns across pins that use all five detection types. Every set bit it observes was cleared and set again on the same edge. A second pass drives pseudo-random clear masks, mask values and direction vectors, so sticky bits, partial clears and output-pin toggles all appear. Directed steps then change the mask between edges to show the request line follows it without a clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        DET_EDGE_FALL  = 3'd0,
        DET_EDGE_RISE  = 3'd1,
        DET_EDGE_ANY   = 3'd2,
        DET_LEVEL_LOW  = 3'd3,
        DET_LEVEL_HIGH = 3'd4
    } det_mode_e;

    function automatic det_mode_e decode_mode(input logic sense, input logic both, input logic pol);
        if (sense)
            return pol ? DET_LEVEL_HIGH : DET_LEVEL_LOW;
        else if (both)
            return DET_EDGE_ANY;
        else
            return pol ? DET_EDGE_RISE : DET_EDGE_FALL;
    endfunction

endpackage

// File: rtl/gpio_pin_capture.sv
module gpio_pin_capture #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_dir,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] data_next,
    output logic [NPINS-1:0] changed
);
    localparam int unsigned W = NPINS;

    typedef struct packed {
        logic [W-1:0] data;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.data = (st_q.data & pin_dir) | (pin_in & ~pin_dir);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign data_q    = st_q.data;
    assign data_next = st_d.data;
    assign changed   = st_d.data ^ st_q.data;

    p_hold_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((data_q ^ $past(data_q)) & $past(pin_dir)) == '0))
        else $error("output pin data changed");

    p_input_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((data_q ^ $past(pin_in)) & ~$past(pin_dir)) == '0))
        else $error("input pin data did not follow pin");

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic [NPINS-1:0] det_sense,
    input  logic [NPINS-1:0] det_both,
    input  logic [NPINS-1:0] det_pol,
    input  logic [NPINS-1:0] data_next,
    input  logic [NPINS-1:0] changed,
    output logic [NPINS-1:0] set_vec
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        det_mode_e mode;
        logic      hit;

        assign mode = decode_mode(det_sense[i], det_both[i], det_pol[i]);

        always_comb begin
            case (mode)
                DET_EDGE_FALL:  hit = changed[i] & ~data_next[i];
                DET_EDGE_RISE:  hit = changed[i] &  data_next[i];
                DET_EDGE_ANY:   hit = changed[i];
                DET_LEVEL_LOW:  hit = ~data_next[i];
                DET_LEVEL_HIGH: hit =  data_next[i];
                default:        hit = 1'b0;
            endcase
        end

        assign set_vec[i] = hit;
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] set_vec,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_mask,
    input  logic [NPINS-1:0] irq_mask,
    output logic [NPINS-1:0] raw_q,
    output logic [NPINS-1:0] masked,
    output logic             irq
);
    localparam int unsigned W = NPINS;

    typedef struct packed {
        logic [W-1:0] raw;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff     = clr_we ? clr_mask : '0;
        st_d        = st_q;
        st_d.raw    = (st_q.raw & ~clr_eff) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign raw_q  = st_q.raw;
    assign masked = st_q.raw & irq_mask;
    assign irq    = |masked;

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_vec) & ~raw_q) == '0))
        else $error("event lost");

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (($past(clr_mask) & ~$past(set_vec) & raw_q) == '0))
        else $error("clear ignored");

    p_raw_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(set_vec)) == '0))
        else $error("raw bit set without event");

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_dir,
    input  logic [NPINS-1:0] det_sense,
    input  logic [NPINS-1:0] det_both,
    input  logic [NPINS-1:0] det_pol,
    input  logic [NPINS-1:0] irq_mask,
    input  logic             clr_we,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] pin_data,
    output logic [NPINS-1:0] raw_status,
    output logic [NPINS-1:0] masked_status,
    output logic             irq
);
    logic [NPINS-1:0] data_next;
    logic [NPINS-1:0] changed;
    logic [NPINS-1:0] set_vec;

    gpio_pin_capture #(.NPINS(NPINS)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .pin_dir   (pin_dir),
        .data_q    (pin_data),
        .data_next (data_next),
        .changed   (changed)
    );

    gpio_event_detect #(.NPINS(NPINS)) u_detect (
        .det_sense (det_sense),
        .det_both  (det_both),
        .det_pol   (det_pol),
        .data_next (data_next),
        .changed   (changed),
        .set_vec   (set_vec)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .irq_mask (irq_mask),
        .raw_q    (raw_status),
        .masked   (masked_status),
        .irq      (irq)
    );

    p_level_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(det_sense & det_pol & pin_in & ~pin_dir) & ~raw_status) == '0))
        else $error("high level not latched");

    p_level_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(det_sense & ~det_pol & ~pin_in & ~pin_dir) & ~raw_status) == '0))
        else $error("low level not latched");

    p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((irq_mask & raw_status) != '0))
        else $error("request without enabled status");

endmodule

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0, pin_dir = '0, det_sense = '0, det_both = '0, det_pol = '0;
    logic [7:0] irq_mask = '0, clr_mask = '0;
    logic       clr_we = 1'b0;
    logic [7:0] pin_data, raw_status, masked_status;
    logic       irq;

    int tests = 0;
    int fails = 0;
    logic [7:0] m_data = '0;
    logic [7:0] m_raw = '0;
    logic [7:0] lfsr = 8'h5A;

    always #2.5 clk = ~clk;

    gpio_irq_detect #(.NPINS(8)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
        .det_sense(det_sense), .det_both(det_both), .det_pol(det_pol),
        .irq_mask(irq_mask), .clr_we(clr_we), .clr_mask(clr_mask),
        .pin_data(pin_data), .raw_status(raw_status),
        .masked_status(masked_status), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] next_lfsr(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    // Model per requirements R2-R8, then one clock, then compare.
    task automatic step(input string tag);
        logic [7:0] nd, setv, clr, nr;
        nd = (m_data & pin_dir) | (pin_in & ~pin_dir);
        for (int i = 0; i < 8; i++) begin
            logic ch, want;
            ch   = nd[i] ^ m_data[i];
            want = det_pol[i] ? nd[i] : ~nd[i];
            if (det_sense[i])     setv[i] = want;
            else if (det_both[i]) setv[i] = ch;
            else                  setv[i] = ch & want;
        end
        clr = clr_we ? clr_mask : 8'h00;
        nr  = (m_raw & ~clr) | setv;
        @(posedge clk);
        @(negedge clk);
        m_data = nd;
        m_raw  = nr;
        chk(pin_data, m_data, "R2 data");
        chk(raw_status, m_raw, tag);
        chk(masked_status, m_raw & irq_mask, "R6 masked");
        chk({7'd0, irq}, {7'd0, |(m_raw & irq_mask)}, "R6 irq");
        clr_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pin_data, 8'h00, "R1 data");
        chk(raw_status, 8'h00, "R1 raw");
        chk({7'd0, irq}, 8'h00, "R1 irq");
        rst_n = 1'b1;
        @(negedge clk);

        // Pin modes: 0 fall, 1 rise, 2/3 either, 4 low, 5 high, 6 low, 7 high
        det_sense = 8'hF0;
        det_both  = 8'hCC;
        det_pol   = 8'hAA;
        irq_mask  = 8'hFF;

        // Exhaustive pattern walk with a full clear every edge: R3 R4 R5 R8
        for (int v = 0; v < 256; v++) begin
            pin_in   = v[7:0];
            clr_we   = 1'b1;
            clr_mask = 8'hFF;
            step("R3 R4 R5 R8 raw");
        end
        for (int v = 0; v < 256; v++) begin
            pin_in   = v[7:0] ^ (v[7:0] >> 1);
            clr_we   = 1'b1;
            clr_mask = 8'hFF;
            step("R3 R4 R5 R8 gray raw");
        end

        // Random walk with partial clears and masks: R7 R6
        for (int n = 0; n < 400; n++) begin
            lfsr     = next_lfsr(lfsr);
            pin_in   = lfsr;
            lfsr     = next_lfsr(lfsr);
            clr_we   = lfsr[0];
            clr_mask = lfsr ^ 8'h3C;
            irq_mask = lfsr ^ 8'hA5;
            step("R7 raw");
        end

        // Direction changes with edge-only pins: R2 R9
        det_sense = 8'h00;
        det_both  = 8'hFF;
        clr_we    = 1'b1;
        clr_mask  = 8'hFF;
        step("R9 clear");
        for (int n = 0; n < 400; n++) begin
            lfsr    = next_lfsr(lfsr);
            pin_dir = lfsr;
            lfsr    = next_lfsr(lfsr);
            pin_in  = lfsr;
            clr_we  = lfsr[1];
            clr_mask = 8'hFF;
            step("R9 R2 raw");
        end

        // R9 directed: all outputs, toggle every pin, no status
        pin_dir  = 8'hFF;
        clr_we   = 1'b1;
        clr_mask = 8'hFF;
        step("R9 clear");
        pin_in = ~pin_in;
        step("R9 output toggle");
        chk(raw_status, 8'h00, "R9 output toggle raw");

        // R8 directed: rising edge on pin 1 with clear of pin 1
        pin_dir = 8'h00; det_both = 8'h00; det_pol = 8'h02; det_sense = 8'h00;
        pin_in = 8'h00;
        clr_we = 1'b1; clr_mask = 8'hFF;
        step("R8 setup");
        pin_in = 8'h02; clr_we = 1'b1; clr_mask = 8'h02;
        step("R8 raw");
        chk(raw_status & 8'h02, 8'h02, "R8 set wins");

        // R5 directed: high level on pin 5 persists over clear
        det_sense = 8'h20; det_pol = 8'h20; pin_in = 8'h20;
        step("R5 level");
        clr_we = 1'b1; clr_mask = 8'h20;
        step("R5 level after clear");
        chk(raw_status & 8'h20, 8'h20, "R5 persist");

        // R6: mask change reaches irq without a clock edge
        irq_mask = 8'h00;
        #1;
        chk({7'd0, irq}, 8'h00, "R6 mask off");
        irq_mask = 8'h20;
        #1;
        chk({7'd0, irq}, 8'h01, "R6 mask on");
        chk(masked_status, m_raw & 8'h20, "R6 masked comb");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule